// File: doc/BRIEF.md
# ADC Sample-Phase Timing Controller

This block runs the timing of one successive-approximation conversion in cycles of the conversion clock. A start request opens a sample phase. During that phase the sample-and-hold enable stays high for a number of cycles set by four things: whether this is the first conversion since the start, the short/long sampling choice, a 2-bit long-sample length code and a high-speed mode bit. A fixed conversion phase follows. In that phase one comparator decision bit per cycle is shifted into a result word, MSB first. At the end, a single-cycle done pulse goes out and the word is committed to the result register.

With continuous mode enabled, the next sample phase begins in the cycle right after done and uses the shorter subsequent-conversion length. An abort request returns the block to idle and leaves the result register alone. A low-power stop request also returns it to idle, but clears the result. A start request that arrives while a conversion is running throws that conversion away and begins again with the first-conversion length. In idle no counter moves.

Top module: `adc_sample_seq`

## Requirements
- R1: After reset, and while idle with no start request, sampleEn, convBusy, busy and done are all 0 and result is 0. A start request sampled at a clock edge raises sampleEn in the next cycle.
- R2: With longSel=0 and hiSpeed=0, sampleEn is high for 6 cycles on the first conversion after a start. In continuous mode each later conversion samples for 4 cycles.
- R3: With longSel=1 and hiSpeed=0, longCode values 0, 1, 2 and 3 give 24, 16, 10 and 6 sample cycles. First and later conversions get the same length.
- R4: hiSpeed=1 adds 2 sample cycles to every length: short first 8, short later 6, long codes 0..3 give 26, 18, 12 and 8.
- R5: Right after the sample phase, convBusy is high for exactly 16 cycles. cmpBit is captured once per cycle, the first capture landing in result bit 15. The next cycle has done=1 for one cycle only, and result holds the 16 captured bits in that same cycle.
- R6: In continuous mode (contEn=1 while done is high), sampleEn rises in the cycle right after done. With contEn=0, the block goes idle instead.
- R7: abortReq returns the block to idle by the next cycle. No done is produced, and result keeps the value of the last completed conversion, even when the abort lands in the final conversion cycle. abortReq takes priority over a simultaneous startReq.
- R8: lpStop returns the block to idle by the next cycle and clears result to 0.
- R9: startReq while busy restarts the sample phase, and that phase uses the first-conversion length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lpStop | input | 1 | Low-power stop: go idle and clear the result |
| startReq | input | 1 | Start (or restart) a conversion sequence |
| contEn | input | 1 | Continuous mode: chain another conversion after done |
| abortReq | input | 1 | Abandon the running conversion, keep the result |
| longSel | input | 1 | 1 selects long sampling |
| longCode | input | 2 | Long-sample length code |
| hiSpeed | input | 1 | High-speed mode, adds 2 sample cycles |
| cmpBit | input | 1 | Comparator decision for the current conversion cycle |
| sampleEn | output | 1 | Sample-and-hold enable |
| convBusy | output | 1 | Conversion phase in progress |
| busy | output | 1 | Any non-idle state |
| done | output | 1 | One-cycle pulse when result is updated |
| result | output | 16 | Last completed conversion word |

## Verification
The bench measures the width of every sampleEn run and compares it with a length computed from the configuration. A design that applied the first-conversion adder to every conversion, or dropped the high-speed adder on long code 3, would show up as a wrong count. An abort placed in the very last conversion cycle targets a design that commits before it checks for the abort; such a design would overwrite the kept result and emit a stray done. A restart during the conversion phase catches a design that keeps the subsequent length or the partial shift state, and the continuous runs catch a one-cycle gap or overlap between done and the next sampling.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SAMP = 2'd1,
    ST_CONV = 2'd2,
    ST_DONE = 2'd3
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftEn;  // capture cmpBit into the shift register
    logic commit;   // move the completed word into the result register
    logic clear;    // return shift and result registers to reset value
  } dpStrobe_t;

  function automatic int maxOf3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/adc_seq_len.sv
module adc_seq_len #(
  parameter int SHORT_LEN = 4,
  parameter int FIRST_ADD = 2,
  parameter int HS_ADD    = 2,
  parameter int LONG_LEN0 = 24,
  parameter int LONG_LEN1 = 16,
  parameter int LONG_LEN2 = 10,
  parameter int LONG_LEN3 = 6,
  parameter int CNT_W     = 5
) (
  input  logic             firstConv,
  input  logic             longSel,
  input  logic [1:0]       longCode,
  input  logic             hiSpeed,
  output logic [CNT_W-1:0] sampLen
);

  localparam logic [CNT_W-1:0] SHORT_FIRST = CNT_W'(SHORT_LEN + FIRST_ADD);
  localparam logic [CNT_W-1:0] SHORT_NEXT  = CNT_W'(SHORT_LEN);

  logic [CNT_W-1:0] longTab [4];
  logic [CNT_W-1:0] baseLen;

  assign longTab[0] = CNT_W'(LONG_LEN0);
  assign longTab[1] = CNT_W'(LONG_LEN1);
  assign longTab[2] = CNT_W'(LONG_LEN2);
  assign longTab[3] = CNT_W'(LONG_LEN3);

  always_comb begin
    if (longSel) begin
      baseLen = longTab[longCode];
    end else begin
      baseLen = firstConv ? SHORT_FIRST : SHORT_NEXT;
    end
  end

  generate
    if (HS_ADD > 0) begin : g_hsAdder
      assign sampLen = hiSpeed ? (baseLen + CNT_W'(HS_ADD)) : baseLen;
    end else begin : g_noHsAdder
      logic unusedHs;
      assign unusedHs = hiSpeed;
      assign sampLen  = baseLen;
    end
  endgenerate

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lpStop,
  input  logic             startReq,
  input  logic             contEn,
  input  logic             abortReq,
  input  logic [CNT_W-1:0] sampLen,
  output logic             firstConv,
  output dpStrobe_t        stb,
  output logic             sampleEn,
  output logic             convBusy,
  output logic             busy,
  output logic             done
);

  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(RES_W - 1);
  localparam logic [CNT_W-1:0] CNT_ZERO  = '0;
  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

  seqState_e        state, nState;
  logic [CNT_W-1:0] cnt, nCnt;
  logic             cntZero;

  assign cntZero   = (cnt == CNT_ZERO);
  // only an explicit start selects the first-conversion length
  assign firstConv = startReq;

  always_comb begin
    nState = state;
    nCnt   = cnt;
    stb    = '0;
    if (lpStop) begin
      nState    = ST_IDLE;
      nCnt      = CNT_ZERO;
      stb.clear = 1'b1;
    end else if (abortReq) begin
      nState = ST_IDLE;
      nCnt   = CNT_ZERO;
    end else if (startReq) begin
      nState = ST_SAMP;
      nCnt   = sampLen - CNT_ONE;
    end else begin
      case (state)
        ST_SAMP: begin
          if (cntZero) begin
            nState = ST_CONV;
            nCnt   = CONV_LAST;
          end else begin
            nCnt = cnt - CNT_ONE;
          end
        end
        ST_CONV: begin
          stb.shiftEn = 1'b1;
          if (cntZero) begin
            stb.commit = 1'b1;
            nState     = ST_DONE;
          end else begin
            nCnt = cnt - CNT_ONE;
          end
        end
        ST_DONE: begin
          if (contEn) begin
            nState = ST_SAMP;
            nCnt   = sampLen - CNT_ONE;
          end else begin
            nState = ST_IDLE;
          end
        end
        default: begin
          nState = ST_IDLE;
          nCnt   = CNT_ZERO;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= CNT_ZERO;
    end else begin
      state <= nState;
      cnt   <= nCnt;
    end
  end

  assign sampleEn = (state == ST_SAMP);
  assign convBusy = (state == ST_CONV);
  assign done     = (state == ST_DONE);
  assign busy     = (state != ST_IDLE);

endmodule

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic             cmpBit,
  output logic [RES_W-1:0] result
);

  logic [RES_W-1:0] shiftReg;
  logic [RES_W-1:0] shiftNext;

  assign shiftNext = {shiftReg[RES_W-2:0], cmpBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      result   <= '0;
    end else if (stb.clear) begin
      shiftReg <= '0;
      result   <= '0;
    end else begin
      if (stb.shiftEn) shiftReg <= shiftNext;
      if (stb.commit)  result   <= shiftNext;
    end
  end

endmodule

// File: rtl/adc_sample_seq.sv
module adc_sample_seq
  import adc_seq_pkg::*;
#(
  parameter int RES_W     = 16,
  parameter int SHORT_LEN = 4,
  parameter int FIRST_ADD = 2,
  parameter int HS_ADD    = 2,
  parameter int LONG_LEN0 = 24,
  parameter int LONG_LEN1 = 16,
  parameter int LONG_LEN2 = 10,
  parameter int LONG_LEN3 = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lpStop,
  input  logic             startReq,
  input  logic             contEn,
  input  logic             abortReq,
  input  logic             longSel,
  input  logic [1:0]       longCode,
  input  logic             hiSpeed,
  input  logic             cmpBit,
  output logic             sampleEn,
  output logic             convBusy,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] result
);

  localparam int LONG_MAX = maxOf3(LONG_LEN0, LONG_LEN1, maxOf3(LONG_LEN2, LONG_LEN3, 0));
  localparam int MAX_CNT  = maxOf3(LONG_MAX + HS_ADD, SHORT_LEN + FIRST_ADD + HS_ADD, RES_W);
  localparam int CNT_W    = $clog2(MAX_CNT + 1);

  dpStrobe_t        stb;
  logic [CNT_W-1:0] sampLen;
  logic             firstConv;

  adc_seq_len #(
    .SHORT_LEN (SHORT_LEN),
    .FIRST_ADD (FIRST_ADD),
    .HS_ADD    (HS_ADD),
    .LONG_LEN0 (LONG_LEN0),
    .LONG_LEN1 (LONG_LEN1),
    .LONG_LEN2 (LONG_LEN2),
    .LONG_LEN3 (LONG_LEN3),
    .CNT_W     (CNT_W)
  ) uLen (
    .firstConv (firstConv),
    .longSel   (longSel),
    .longCode  (longCode),
    .hiSpeed   (hiSpeed),
    .sampLen   (sampLen)
  );

  adc_seq_ctrl #(
    .RES_W (RES_W),
    .CNT_W (CNT_W)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .lpStop    (lpStop),
    .startReq  (startReq),
    .contEn    (contEn),
    .abortReq  (abortReq),
    .sampLen   (sampLen),
    .firstConv (firstConv),
    .stb       (stb),
    .sampleEn  (sampleEn),
    .convBusy  (convBusy),
    .busy      (busy),
    .done      (done)
  );

  adc_seq_dp #(
    .RES_W (RES_W)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .cmpBit (cmpBit),
    .result (result)
  );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int RES_W     = 16,
  parameter int SHORT_LEN = 4,
  parameter int FIRST_ADD = 2,
  parameter int HS_ADD    = 2,
  parameter int LONG_LEN0 = 24,
  parameter int LONG_LEN1 = 16,
  parameter int LONG_LEN2 = 10,
  parameter int LONG_LEN3 = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             lpStop,
  input logic             startReq,
  input logic             contEn,
  input logic             abortReq,
  input logic             sampleEn,
  input logic             convBusy,
  input logic             busy,
  input logic             done,
  input logic [RES_W-1:0] result
);

  logic [7:0] sampCnt;
  logic [7:0] convCnt;
  logic       lenOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampCnt <= '0;
      convCnt <= '0;
    end else begin
      if (startReq || done) sampCnt <= '0;
      else if (sampleEn)    sampCnt <= sampCnt + 8'd1;
      convCnt <= convBusy ? (convCnt + 8'd1) : 8'd0;
    end
  end

  function automatic logic legalLen(input int n);
    int k;
    logic ok;
    ok = 1'b0;
    for (k = 0; k < 2; k++) begin
      if (n == SHORT_LEN + FIRST_ADD + k * HS_ADD) ok = 1'b1;
      if (n == SHORT_LEN + k * HS_ADD)             ok = 1'b1;
      if (n == LONG_LEN0 + k * HS_ADD)             ok = 1'b1;
      if (n == LONG_LEN1 + k * HS_ADD)             ok = 1'b1;
      if (n == LONG_LEN2 + k * HS_ADD)             ok = 1'b1;
      if (n == LONG_LEN3 + k * HS_ADD)             ok = 1'b1;
    end
    return ok;
  endfunction

  assign lenOk = legalLen(int'(sampCnt));

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !startReq) |=> (!sampleEn && !convBusy)); // R1

  AST_SAMPLE_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convBusy) |-> lenOk); // R3

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleEn && convBusy)); // R5

  AST_CONV_SPAN: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (convCnt == 8'(RES_W))); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R5

  AST_CONT_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (done && contEn && !abortReq && !lpStop) |=> sampleEn); // R6

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |=> !busy); // R7

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(result) |-> (done || $past(lpStop))); // R7

  AST_LPSTOP_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    lpStop |=> ((result == '0) && !busy)); // R8

endmodule

bind adc_sample_seq adc_seq_chk #(
  .RES_W     (RES_W),
  .SHORT_LEN (SHORT_LEN),
  .FIRST_ADD (FIRST_ADD),
  .HS_ADD    (HS_ADD),
  .LONG_LEN0 (LONG_LEN0),
  .LONG_LEN1 (LONG_LEN1),
  .LONG_LEN2 (LONG_LEN2),
  .LONG_LEN3 (LONG_LEN3)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .lpStop   (lpStop),
  .startReq (startReq),
  .contEn   (contEn),
  .abortReq (abortReq),
  .sampleEn (sampleEn),
  .convBusy (convBusy),
  .busy     (busy),
  .done     (done),
  .result   (result)
);

// File: tb/sim_adc_sample_seq.sv
`timescale 1ns/1ps
module sim_adc_sample_seq;

  localparam int RES_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lpStop = 1'b0, startReq = 1'b0, contEn = 1'b0, abortReq = 1'b0;
  logic longSel = 1'b0, hiSpeed = 1'b0, cmpBit = 1'b0;
  logic [1:0] longCode = 2'd0;
  logic sampleEn, convBusy, busy, done;
  logic [RES_W-1:0] result;

  always #2.5 clk = ~clk;

  adc_sample_seq u0 (
    .clk(clk), .rstN(rstN), .lpStop(lpStop), .startReq(startReq),
    .contEn(contEn), .abortReq(abortReq), .longSel(longSel),
    .longCode(longCode), .hiSpeed(hiSpeed), .cmpBit(cmpBit),
    .sampleEn(sampleEn), .convBusy(convBusy), .busy(busy),
    .done(done), .result(result)
  );

  typedef struct {
    int               len;
    logic [RES_W-1:0] res;
    string            tag;
  } exp_t;

  exp_t             expQ[$];
  int               nChecks = 0;
  int               nFails = 0;
  bit               finished = 1'b0;
  logic [RES_W-1:0] curPat = '0;
  int               pIdx = 0;
  int               runLen = 0;
  int               measLen = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // expected sample length straight from the requirements
  function automatic int refLen(input bit first, input bit ls,
                                input logic [1:0] code, input bit hs);
    int n;
    if (ls) begin
      case (code)
        2'd0: n = 24;
        2'd1: n = 16;
        2'd2: n = 10;
        default: n = 6;
      endcase
    end else begin
      n = first ? 6 : 4;
    end
    if (hs) n += 2;
    return n;
  endfunction

  // comparator model: present pattern bits MSB first during conversion
  always @(negedge clk) begin
    if (convBusy) begin
      cmpBit = curPat[RES_W-1-pIdx];
      pIdx++;
    end else begin
      pIdx = 0;
    end
  end

  // monitor: measure sample windows, pop and compare on done
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (sampleEn) runLen++;
      else begin
        if (runLen > 0) measLen = runLen;
        runLen = 0;
      end
      if (done) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R7", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check(measLen == e.len, e.tag, "sample length", measLen, e.len);
          check(result == e.res, "R5", "result word", result, e.res);
        end
      end
    end
  end

  task automatic setCfg(input bit ls, input logic [1:0] code, input bit hs);
    longSel = ls; longCode = code; hiSpeed = hs;
  endtask

  task automatic pulseStart();
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic waitDone();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!done && guard < 200);
    if (!done) check(1'b0, "R5", "done timeout", 0, 1);
  endtask

  task automatic single(input bit ls, input logic [1:0] code, input bit hs,
                        input logic [RES_W-1:0] pat, input string tag);
    exp_t e;
    setCfg(ls, code, hs);
    curPat = pat;
    e.len = refLen(1'b1, ls, code, hs); e.res = pat; e.tag = tag;
    expQ.push_back(e);
    pulseStart();
    waitDone();
    @(negedge clk);
  endtask

  task automatic contRun(input bit ls, input logic [1:0] code, input bit hs,
                         input int n, input logic [RES_W-1:0] basePat, input string tag);
    exp_t e;
    setCfg(ls, code, hs);
    for (int i = 0; i < n; i++) begin
      e.len = refLen(i == 0, ls, code, hs);
      e.res = basePat ^ RES_W'(i * 16'h1357);
      e.tag = tag;
      expQ.push_back(e);
    end
    contEn = 1'b1;
    curPat = basePat;
    pulseStart();
    for (int i = 0; i < n; i++) begin
      waitDone();
      curPat = basePat ^ RES_W'((i + 1) * 16'h1357);
      @(negedge clk);
      if (i < n - 1) begin
        check(sampleEn == 1'b1, "R6", "sample starts after done", sampleEn, 1);
        if (i == n - 2) contEn = 1'b0;
      end else begin
        check(busy == 1'b0, "R6", "idle after last done", busy, 0);
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int seen;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(result == '0, "R1", "result at reset", result, 0);
    check({sampleEn, convBusy, busy, done} == 4'b0, "R1", "outputs at reset",
          {sampleEn, convBusy, busy, done}, 0);
    rstN = 1'b1;
    seen = 0;
    repeat (20) begin
      @(negedge clk);
      if (sampleEn || convBusy || busy || done) seen++;
    end
    check(seen == 0, "R1", "idle activity", seen, 0);
    // R1: start sampled at edge gives sampleEn in next cycle
    setCfg(1'b0, 2'd0, 1'b0);
    curPat = 16'hA5C3;
    begin
      exp_t e;
      e.len = 6; e.res = 16'hA5C3; e.tag = "R2";
      expQ.push_back(e);
    end
    pulseStart();
    check(sampleEn == 1'b1, "R1", "sampleEn after start", sampleEn, 1);
    waitDone();
    @(negedge clk);

    // R2 short sampling
    contRun(1'b0, 2'd0, 1'b0, 3, 16'h8001, "R2");
    // R3 long codes
    single(1'b1, 2'd0, 1'b0, 16'hFFFF, "R3");
    single(1'b1, 2'd1, 1'b0, 16'h0000, "R3");
    single(1'b1, 2'd2, 1'b0, 16'h5A5A, "R3");
    single(1'b1, 2'd3, 1'b0, 16'h0F0F, "R3");
    contRun(1'b1, 2'd1, 1'b0, 2, 16'h4321, "R3");
    // R4 high-speed adder
    single(1'b0, 2'd0, 1'b1, 16'h1111, "R4");
    contRun(1'b0, 2'd0, 1'b1, 2, 16'hC001, "R4");
    single(1'b1, 2'd0, 1'b1, 16'h2222, "R4");
    single(1'b1, 2'd1, 1'b1, 16'h3333, "R4");
    single(1'b1, 2'd2, 1'b1, 16'h4444, "R4");
    single(1'b1, 2'd3, 1'b1, 16'h7FFE, "R4");

    // R7: abort mid conversion keeps result
    single(1'b0, 2'd0, 1'b0, 16'h1234, "R2");
    curPat = 16'hFFFF;
    pulseStart();
    repeat (10) @(negedge clk);
    abortReq = 1'b1;
    @(negedge clk);
    abortReq = 1'b0;
    check(busy == 1'b0, "R7", "idle after abort", busy, 0);
    repeat (30) @(negedge clk);
    check(result == 16'h1234, "R7", "result kept after abort", result, 16'h1234);

    // R7: abort in the final conversion cycle
    pulseStart();
    repeat (21) @(negedge clk);
    abortReq = 1'b1;
    @(negedge clk);
    abortReq = 1'b0;
    check(done == 1'b0, "R7", "no done on late abort", done, 0);
    check(result == 16'h1234, "R7", "result kept on late abort", result, 16'h1234);

    // R7: abort during sampling, then abort with simultaneous start
    pulseStart();
    repeat (2) @(negedge clk);
    abortReq = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R7", "idle after sample abort", busy, 0);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0; abortReq = 1'b0;
    check(busy == 1'b0, "R7", "abort beats start", busy, 0);
    repeat (5) @(negedge clk);

    // R8: low-power stop clears result
    pulseStart();
    repeat (8) @(negedge clk);
    lpStop = 1'b1;
    @(negedge clk);
    lpStop = 1'b0;
    check(busy == 1'b0, "R8", "idle after lpStop", busy, 0);
    check(result == '0, "R8", "result cleared", result, 0);
    repeat (5) @(negedge clk);

    // R9: restart during conversion uses the first-conversion length
    setCfg(1'b0, 2'd0, 1'b0);
    curPat = 16'h9C3E;
    begin
      exp_t e;
      e.len = 6; e.res = 16'h9C3E; e.tag = "R9";
      expQ.push_back(e);
    end
    contEn = 1'b1;
    pulseStart();
    repeat (10) @(negedge clk);
    contEn = 1'b0;
    pulseStart();
    waitDone();
    @(negedge clk);
    check(busy == 1'b0, "R9", "idle after restarted run", busy, 0);

    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R5", "pending expected items", expQ.size(), 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule